// File: doc/BRIEF.md
# Register-Programmed Power-of-Two Clock Divider Bank

This block takes a reference clock and produces a set of gated output clocks. Each output runs at the reference rate divided by 1, 2, 4, 8, 16, 32 or 64. Software picks the ratio with a 3-bit code in a small per-channel register window. A second register holds the start/stop bit, and reading that register shows whether the output is actually running. Every channel has an identical window of 256 bytes, and the windows are stacked: the upper address bits pick the channel and the low eight bits pick the register inside it.

Output is started and stopped only at a low phase, so software never sees a shortened pulse. The latency from the write to the first edge is fixed and can be computed from the ratio, and so is the latency to a clean stop. A ratio code written while the output runs is stored right away but is applied only at the next start. This lets software follow a "stop, reprogram, restart" sequence, and it also keeps a careless write from breaking the running clock.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every channel has its enable at 0 and its code at 0, every output is low, and every register reads 0.
- R2: The ratio code sits in bits [2:0] of offset 0x43. A write stores wdata[2:0] and ignores the upper bits. A read returns the stored code with bits [7:3] equal to 0.
- R3: At offset 0x46, bit 7 is the enable, and it reads back as written. Bit 0 reads 1 while the output is running or stopping and 0 once it has stopped. All other bits read 0.
- R4: Codes 0 and 1 pass the reference clock through (ratio 1). A code c from 2 to 7 gives a square wave of period 2^(c-1) reference cycles, high for half the period and low for the other half.
- R5: Writes are captured on the clock edge where acc_en is high. For a ratio R of 2 or more, the first rising output edge comes 1+R/2 edges after the enable write. For R=1 it comes 2 edges after. Both stay within 2+3R.
- R6: After the enable is cleared the output stops within 3R reference cycles and then stays low. A high pulse that is under way finishes at its full R/2 width.
- R7: A code written while the output runs leaves the running ratio unchanged. The new code takes effect at the next enable.
- R8: Writes to any offset other than 0x43 and 0x46 have no effect, and reads of those offsets return 0. Windows whose channel index is N_CH or higher read 0.
- R9: The channels are independent. Channel i is selected by address bits [ADDR_W-1:8] equal to i, and it drives clk_out[i].
- R10: acc_rdata is registered. It carries the read result on the cycle after the read request and is 0 after any cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (10) | {channel index, byte offset} |
| acc_wdata | input | DW (8) | Write data |
| acc_rdata | output | DW (8) | Registered read data |
| clk_out | output | N_CH (3) | Gated divided clocks |

## Verification
A channel whose sequencer state is wrong shows up at its output pin within one output period. A stuck counter or a wrong latched ratio changes the measured high or low width on the next pulse. A sequencer stuck in its stopping state leaves bit 0 of the enable register set when software reads it after the stop window. A ratio register that picks up a write while running changes the very next pulse width. A premature stop shows up as a high pulse that is shorter than the programmed half-period. Read-path faults show up on acc_rdata one cycle after the faulty request.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_RUN  = 2'd1,
      ST_STOP = 2'd2
   } seq_state_e;

   function automatic logic code_is_bypass(input int unsigned code);
      return code <= 1;
   endfunction
endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs #(
   parameter int CODE_W = 3,
   parameter int DW     = 8,
   parameter int WIN_W  = 8,
   parameter logic [WIN_W-1:0] OFF_CODE = 8'h43,
   parameter logic [WIN_W-1:0] OFF_EN   = 8'h46,
   parameter int EN_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WIN_W-1:0]  off_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [CODE_W-1:0] code_o,
   output logic              en_o
);
   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
         en_o   <= 1'b0;
      end else if (wr_i) begin
         if (off_i == OFF_CODE) code_o <= wdata_i[CODE_W-1:0];
         if (off_i == OFF_EN)   en_o   <= wdata_i[EN_BIT];
      end
   end

   p_code_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && off_i == OFF_CODE) |=> code_o == $past(wdata_i[CODE_W-1:0]));

   p_unused_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && off_i != OFF_CODE && off_i != OFF_EN) |=> ($stable(code_o) && $stable(en_o)));
endmodule

// File: rtl/clkdiv_seq.sv
`timescale 1ns/1ps
module clkdiv_seq #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              div_o,
   output logic              bypass_o,
   output logic              running_o
);
   import clkdiv_pkg::*;

   localparam int MAX_CODE = (1 << CODE_W) - 1;
   localparam int CNT_W    = MAX_CODE - 1;

   seq_state_e        state_q;
   logic [CODE_W-1:0] act_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  half_m1;
   logic              div_q;
   logic              byp;
   logic              tick;

   always_comb begin
      byp     = code_is_bypass(32'(act_q));
      half_m1 = '0;
      if (!byp) half_m1 = CNT_W'((32'd1 << (32'(act_q) - 32'd2)) - 32'd1);
      tick = !byp && (cnt_q == half_m1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         act_q   <= '0;
         cnt_q   <= '0;
         div_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_OFF: begin
               cnt_q <= '0;
               div_q <= 1'b0;
               if (en_i) begin
                  act_q   <= code_i;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (!en_i && (byp || !div_q)) begin
                  state_q <= ST_OFF;
                  cnt_q   <= '0;
               end else begin
                  if (tick) begin
                     cnt_q <= '0;
                     div_q <= ~div_q;
                  end else if (!byp) begin
                     cnt_q <= cnt_q + 1'b1;
                  end
                  if (!en_i) state_q <= tick ? ST_OFF : ST_STOP;
               end
            end
            ST_STOP: begin
               if (tick) begin
                  cnt_q   <= '0;
                  div_q   <= 1'b0;
                  state_q <= ST_OFF;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_OFF;
         endcase
      end
   end

   assign div_o     = div_q;
   assign running_o = (state_q != ST_OFF);
   assign bypass_o  = byp;

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_OFF) |-> (cnt_q <= half_m1));

   p_full_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(div_q) |-> ($past(cnt_q) == half_m1));

   p_ratio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_OFF && $past(state_q) != ST_OFF) |-> $stable(act_q));

   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OFF) |-> !div_q);
endmodule

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic byp_i,
   input  logic div_i,
   output logic clk_o
);
   logic run_lo;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) run_lo <= 1'b0;
      else        run_lo <= run_i && byp_i;
   end

   assign clk_o = run_lo ? clk : div_i;

   p_bypass_no_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
      byp_i |-> !div_i);
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank #(
   parameter int N_CH   = 3,
   parameter int CODE_W = 3,
   parameter int DW     = 8,
   parameter int WIN_W  = 8,
   parameter logic [WIN_W-1:0] OFF_CODE = 8'h43,
   parameter logic [WIN_W-1:0] OFF_EN   = 8'h46,
   parameter int EN_BIT  = 7,
   parameter int RUN_BIT = 0,
   localparam int SEL_W  = (N_CH > 1) ? $clog2(N_CH + 1) : 1,
   localparam int ADDR_W = SEL_W + WIN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DW-1:0]     acc_wdata,
   output logic [DW-1:0]     acc_rdata,
   output logic [N_CH-1:0]   clk_out
);
   if (N_CH < 1)                         $error("N_CH must be at least 1");
   if (CODE_W < 2 || CODE_W > 4)         $error("CODE_W must be 2..4");
   if (EN_BIT >= DW || RUN_BIT >= DW)    $error("status bits exceed DW");
   if (EN_BIT == RUN_BIT)                $error("EN_BIT and RUN_BIT overlap");
   if (CODE_W > DW)                      $error("CODE_W exceeds DW");
   if (OFF_CODE == OFF_EN)               $error("register offsets overlap");

   logic [SEL_W-1:0]  sel;
   logic [WIN_W-1:0]  off;
   logic              rd_req;
   logic [DW-1:0]     rd_val;
   logic [DW-1:0]     rdata_q;
   logic [CODE_W-1:0] code_v [N_CH];
   logic              en_v   [N_CH];
   logic              run_v  [N_CH];

   assign sel    = acc_addr[ADDR_W-1:WIN_W];
   assign off    = acc_addr[WIN_W-1:0];
   assign rd_req = acc_en && !acc_wr;

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      logic wr_g, div_g, byp_g;

      assign wr_g = acc_en && acc_wr && (sel == SEL_W'(g));

      clkdiv_regs #(
         .CODE_W(CODE_W), .DW(DW), .WIN_W(WIN_W),
         .OFF_CODE(OFF_CODE), .OFF_EN(OFF_EN), .EN_BIT(EN_BIT)
      ) u_regs (
         .clk(clk), .rst_n(rst_n), .wr_i(wr_g), .off_i(off),
         .wdata_i(acc_wdata), .code_o(code_v[g]), .en_o(en_v[g])
      );

      clkdiv_seq #(.CODE_W(CODE_W)) u_seq (
         .clk(clk), .rst_n(rst_n), .en_i(en_v[g]), .code_i(code_v[g]),
         .div_o(div_g), .bypass_o(byp_g), .running_o(run_v[g])
      );

      clkdiv_gate u_gate (
         .clk(clk), .rst_n(rst_n), .run_i(run_v[g]), .byp_i(byp_g),
         .div_i(div_g), .clk_o(clk_out[g])
      );
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (sel == SEL_W'(i)) begin
            if (off == OFF_CODE) rd_val[CODE_W-1:0] = code_v[i];
            if (off == OFF_EN) begin
               rd_val[EN_BIT]  = en_v[i];
               rd_val[RUN_BIT] = run_v[i];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_req) rdata_q <= rd_val;
      else             rdata_q <= '0;
   end

   assign acc_rdata = rdata_q;

   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_req) |-> (acc_rdata == '0));

   p_code_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_req && off == OFF_CODE) |-> (acc_rdata[DW-1:CODE_W] == '0));

   p_empty_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_req && sel >= SEL_W'(N_CH)) |-> (acc_rdata == '0));
endmodule

// File: tb/sim_clkdiv_bank.sv
`timescale 1ns/1ps
module sim_clkdiv_bank;
   localparam int N_CH = 3;
   localparam int ADDR_W = 10;
   localparam logic [7:0] A_CODE = 8'h43;
   localparam logic [7:0] A_EN   = 8'h46;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_en = 1'b0, acc_wr = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic [N_CH-1:0] clk_out;

   int n_checks = 0;
   int n_errs = 0;
   bit done = 1'b0;
   bit rd_pend = 1'b0;
   int    exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   clkdiv_bank u0 (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .clk_out(clk_out)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reg_write(input int ch, input logic [7:0] off, input logic [7:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b1;
      acc_addr = {2'(ch), off}; acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0;
   endtask

   // driver: queue the expected value, then issue the read
   task automatic reg_read(input int ch, input logic [7:0] off, input int exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b0; acc_addr = {2'(ch), off};
      @(posedge clk);
      #1 rd_pend = 1'b1;
      @(negedge clk);
      acc_en = 1'b0;
   endtask

   // monitor: compare the registered read result against the queue head
   always @(negedge clk) begin
      if (rd_pend) begin
         rd_pend = 1'b0;
         check(tag_q.pop_front(), int'(acc_rdata), exp_q.pop_front());
      end
   end

   task automatic wait_rise(input int ch, output int n);
      bit seen_low = 1'b0;
      n = 0;
      while (n < 1000) begin
         @(posedge clk); #1; n++;
         if (!clk_out[ch]) seen_low = 1'b1;
         else if (seen_low) break;
      end
   endtask

   task automatic high_len(input int ch, output int h);
      h = 1;
      while (h < 1000) begin
         @(posedge clk); #1;
         if (clk_out[ch]) h++; else break;
      end
   endtask

   task automatic low_len(input int ch, output int l);
      l = 1;
      while (l < 1000) begin
         @(posedge clk); #1;
         if (!clk_out[ch]) l++; else break;
      end
   endtask

   task automatic wait_low(input int ch, output int n);
      n = 0;
      do begin @(posedge clk); #1; n++; end while (clk_out[ch] && n < 1000);
   endtask

   task automatic count_high(input int ch, input int cycles, output int hits);
      hits = 0;
      for (int i = 0; i < cycles; i++) begin
         @(posedge clk); #1;
         if (clk_out[ch]) hits++;
      end
   endtask

   task automatic bypass_shape(input int ch, input string req);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); #1; check({req, " low phase"}, int'(clk_out[ch]), 0);
         @(posedge clk); #1; check({req, " high phase"}, int'(clk_out[ch]), 1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_errs++;
         $display("FAIL R5 watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   end

   initial begin
      int n, h, l, hits;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(posedge clk); #1;
      check("R1 outputs low", int'(clk_out), 0);
      for (int c = 0; c < N_CH; c++) begin
         reg_read(c, A_CODE, 0, "R1 code reset");
         reg_read(c, A_EN, 0, "R1 enable reset");
      end
      // R10 idle read data
      repeat (2) @(negedge clk);
      #1 check("R10 idle rdata", int'(acc_rdata), 0);

      // channel 0, code 2 -> ratio 2
      reg_write(0, A_CODE, 8'h02);
      reg_read(0, A_CODE, 2, "R2 code readback");
      reg_write(0, A_EN, 8'h80);
      wait_rise(0, n); check("R5 latency ratio 2", n, 2);
      high_len(0, h);  check("R4 high ratio 2", h, 1);
      low_len(0, l);   check("R4 low ratio 2", l, 1);
      reg_read(0, A_EN, 8'h81, "R3 enable and running");
      reg_write(0, A_EN, 8'h00);
      wait_low(0, n);  check("R6 stop ratio 2 within 6", int'(n <= 6), 1);
      count_high(0, 12, hits); check("R6 stays low ratio 2", hits, 0);
      reg_read(0, A_EN, 0, "R3 stopped status");

      // channel 1, code 5 -> ratio 16
      reg_write(1, A_CODE, 8'h05);
      reg_write(1, A_EN, 8'h80);
      wait_rise(1, n); check("R5 latency ratio 16", n, 9);
      check("R5 bound ratio 16", int'(n <= 50), 1);
      high_len(1, h);  check("R4 high ratio 16", h, 8);
      low_len(1, l);   check("R4 low ratio 16", l, 8);
      check("R9 channel 0 idle", int'(clk_out[0]), 0);
      reg_write(1, A_CODE, 8'h03);
      reg_read(1, A_CODE, 3, "R7 code stored while running");
      wait_rise(1, n);
      fork
         reg_write(1, A_EN, 8'h00);
         high_len(1, h);
      join
      check("R7 old ratio kept / R6 full last pulse", h, 8);
      count_high(1, 50, hits); check("R6 stays low ratio 16", hits, 0);
      reg_read(1, A_EN, 0, "R3 status after stop");

      // re-enable picks up new code 3 -> ratio 4
      reg_write(1, A_EN, 8'h80);
      wait_rise(1, n); check("R7 latency new ratio 4", n, 3);
      high_len(1, h);  check("R7 high new ratio 4", h, 2);
      reg_write(1, A_EN, 8'h00);
      wait_low(1, n);  check("R6 stop ratio 4 within 12", int'(n <= 12), 1);

      // channel 2, code 1 and code 0 -> pass-through
      reg_write(2, A_CODE, 8'h01);
      reg_write(2, A_EN, 8'h80);
      wait_rise(2, n); check("R5 latency code 1", n, 2);
      bypass_shape(2, "R4 code 1");
      reg_read(2, A_EN, 8'h81, "R3 bypass running");
      reg_write(2, A_EN, 8'h00);
      wait_low(2, n);  check("R6 stop bypass within 3", int'(n <= 3), 1);
      count_high(2, 6, hits); check("R6 bypass stays low", hits, 0);
      reg_write(2, A_CODE, 8'h00);
      reg_write(2, A_EN, 8'h80);
      wait_rise(2, n); check("R5 latency code 0", n, 2);
      bypass_shape(2, "R4 code 0");
      reg_write(2, A_EN, 8'h00);
      wait_low(2, n);

      // channel 2, code 7 -> ratio 64
      reg_write(2, A_CODE, 8'h07);
      reg_write(2, A_EN, 8'h80);
      wait_rise(2, n); check("R5 latency ratio 64", n, 33);
      high_len(2, h);  check("R4 high ratio 64", h, 32);
      low_len(2, l);   check("R4 low ratio 64", l, 32);
      reg_write(2, A_EN, 8'h00);
      wait_low(2, n);  check("R6 stop ratio 64 within 192", int'(n <= 192), 1);

      // R8 unused offsets and empty window
      reg_write(0, 8'h44, 8'hFF);
      reg_write(0, 8'h00, 8'hFF);
      reg_read(0, 8'h44, 0, "R8 unused offset reads 0");
      reg_read(0, A_CODE, 2, "R8 code untouched");
      reg_read(0, A_EN, 0, "R8 enable untouched");
      check("R8 output untouched", int'(clk_out[0]), 0);
      reg_write(3, A_EN, 8'h80);
      reg_read(3, A_EN, 0, "R8 empty window reads 0");
      count_high(0, 4, hits); check("R9 empty window leaves ch0 idle", hits, 0);

      // R2 upper bits ignored
      reg_write(0, A_CODE, 8'hFF);
      reg_read(0, A_CODE, 7, "R2 upper bits dropped");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end
endmodule